// File: doc/BRIEF.md
# Prefixed Bit-Operation Execution Unit

This unit carries out the second byte of a two-byte instruction class on an 8-bit processor, the byte that follows a prefix escape. That byte selects one of four groups: eight kinds of rotate or shift, a single-bit test, a single-bit clear and a single-bit set. It also names a bit position or shift kind and an operand. The operand is one of seven registers or the byte in memory addressed by the HL register pair. The unit decodes the byte, computes the new value and flags, and hands back register and flag write requests together with a report of how many machine cycles the instruction costs.

The enclosing core pulses `start` with the opcode byte, the current flag nibble and the HL address. For a register operand the core also supplies the selected register's value on `rf_rdata`, which it looks up through `rf_rsel`. Register operands finish one clock after `start`. The memory operand runs a read, then a modify step, then a write. Each memory access waits on a request/acknowledge handshake. The write is left out for the bit test.

Top module: `bitop_exec`

## Requirements
- R1: The opcode byte is decoded in three fields. Bits 7:6 give the group (00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set). Bits 5:3 give the bit index, or the shift kind in group 00. Bits 2:0 give the operand selector.
- R2: Selector codes 0 to 7 name B, C, D, E, H, L, memory at HL, and A. A register code writes its result to `rf_wsel` equal to the selector and never raises a memory request. Code 6 reads and writes memory at `hl_addr` and never raises `rf_we`.
- R3: Group 00 shift kinds 0 to 7 are RLC, RRC, RL, RR, SLA, SRA, SWAP, SRL. RLC/RRC rotate circularly. RL/RR rotate through the carry. SLA fills bit 0 with 0. SRA keeps bit 7. SRL fills bit 7 with 0. SWAP exchanges the nibbles.
- R4: In group 00, C receives bit 7 for the left kinds and bit 0 for the right kinds. SWAP clears C.
- R5: In group 00, Z is 1 exactly when the 8-bit result is zero, and N and H are 0.
- R6: The bit test sets Z to the inverse of the tested bit, N to 0 and H to 1, and keeps C. It writes no register and issues no memory write.
- R7: Bit clear and bit set change only the indexed bit and leave the flags untouched (`flag_we` stays 0).
- R8: A register operand raises `done` in the clock after `start` with `cycles` = 2.
- R9: The memory operand holds `mem_rd_req` with a stable address until `mem_rd_ack`. It then issues the result on `mem_wr_req` until `mem_wr_ack`, with the bit test skipping the write. `done` comes with `cycles` = 4.
- R10: `flags_in` bits 3:0 are Z, N, H, C. `flag_wdata` carries Z, N, H, C in bits 7:4 with bits 3:0 zero.
- R11: `done` is high for exactly one clock. A `start` pulse while the unit is busy is ignored.
- R12: After reset the unit is idle with `busy`, `done`, both memory requests and both write enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse for one instruction |
| opcode | input | 8 | Second opcode byte |
| flags_in | input | 4 | Current flags Z,N,H,C (bit 3 = Z) |
| hl_addr | input | ADDR_W | Memory operand address |
| rf_rsel | output | 3 | Register selector decoded from `opcode` |
| rf_rdata | input | 8 | Value of the selected register |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 3 | Register written |
| rf_wdata | output | 8 | Register write data |
| flag_we | output | 1 | Flag register write enable |
| flag_wdata | output | 8 | New flag register value |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_ack | input | 1 | Memory read acknowledge |
| mem_rd_data | input | 8 | Memory read data, valid with acknowledge |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | ADDR_W | Memory address for both accesses |
| mem_wr_data | output | 8 | Memory write data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-clock completion strobe |
| cycles | output | CNT_W | Machine-cycle cost, valid with `done` |

## Verification
The two functions that can meet in one cycle are the launch of a new instruction and the memory sequencer that is still working on the previous one. The bench raises `start` with a different opcode and a different HL address while a memory instruction waits on its read. It varies the read and write acknowledge delays, so the stray launch lands next to an acknowledge in some runs. It judges the outcome by checking that the memory byte written, the address used and the flags returned all match the first instruction alone, and that only one `done` appears.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NIB_W   = DATA_W / 2;
    localparam int unsigned IDX_W   = $clog2(DATA_W);
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned GRP_LSB = IDX_W + SEL_W;
    localparam int unsigned IDX_LSB = SEL_W;
    localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } shop_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_MODIFY = 3'd2,
        PH_WRITE  = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flg_t;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } dec_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output dec_t              dec,
    output logic              is_mem
);

    always_comb begin
        dec.grp = grp_e'(opcode[GRP_LSB +: 2]);
        dec.idx = opcode[IDX_LSB +: IDX_W];
        dec.sel = opcode[0 +: SEL_W];
        is_mem  = (opcode[0 +: SEL_W] == SEL_MEM);
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  grp_e              grp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] opnd,
    input  flg_t              fin,
    output logic [DATA_W-1:0] res,
    output flg_t              fout,
    output logic              wb,
    output logic              fwe
);

    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] clr_val;
    logic [DATA_W-1:0] set_val;
    logic              tested;

    // Per-bit clear / set: only the indexed position is forced.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bitop
        assign clr_val[i] = (idx == IDX_W'(i)) ? 1'b0 : opnd[i];
        assign set_val[i] = (idx == IDX_W'(i)) ? 1'b1 : opnd[i];
    end

    assign tested = opnd[idx];

    always_comb begin
        sh_res = opnd;
        sh_c   = 1'b0;
        case (shop_e'(idx))
            SH_RLC: begin
                sh_res = {opnd[DATA_W-2:0], opnd[DATA_W-1]};
                sh_c   = opnd[DATA_W-1];
            end
            SH_RRC: begin
                sh_res = {opnd[0], opnd[DATA_W-1:1]};
                sh_c   = opnd[0];
            end
            SH_RL: begin
                sh_res = {opnd[DATA_W-2:0], fin.c};
                sh_c   = opnd[DATA_W-1];
            end
            SH_RR: begin
                sh_res = {fin.c, opnd[DATA_W-1:1]};
                sh_c   = opnd[0];
            end
            SH_SLA: begin
                sh_res = {opnd[DATA_W-2:0], 1'b0};
                sh_c   = opnd[DATA_W-1];
            end
            SH_SRA: begin
                sh_res = {opnd[DATA_W-1], opnd[DATA_W-1:1]};
                sh_c   = opnd[0];
            end
            SH_SWAP: begin
                sh_res = {opnd[NIB_W-1:0], opnd[DATA_W-1:NIB_W]};
                sh_c   = 1'b0;
            end
            SH_SRL: begin
                sh_res = {1'b0, opnd[DATA_W-1:1]};
                sh_c   = opnd[0];
            end
            default: begin
                sh_res = opnd;
                sh_c   = 1'b0;
            end
        endcase
    end

    always_comb begin
        res  = opnd;
        fout = fin;
        wb   = 1'b0;
        fwe  = 1'b0;
        case (grp)
            GRP_SHIFT: begin
                res  = sh_res;
                fout = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_c};
                wb   = 1'b1;
                fwe  = 1'b1;
            end
            GRP_TEST: begin
                res  = opnd;
                fout = '{z: ~tested, n: 1'b0, h: 1'b1, c: fin.c};
                wb   = 1'b0;
                fwe  = 1'b1;
            end
            GRP_CLR: begin
                res  = clr_val;
                fout = fin;
                wb   = 1'b1;
                fwe  = 1'b0;
            end
            GRP_SET: begin
                res  = set_val;
                fout = fin;
                wb   = 1'b1;
                fwe  = 1'b0;
            end
            default: begin
                res  = opnd;
                fout = fin;
            end
        endcase
    end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
    import bitop_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned CNT_W   = 3,
    parameter int unsigned CYC_REG = 2,
    parameter int unsigned CYC_MEM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dec_t              dec,
    input  logic              is_mem,
    input  flg_t              flags_in,
    input  logic [ADDR_W-1:0] hl_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    // ALU hookup
    output grp_e              alu_grp,
    output logic [IDX_W-1:0]  alu_idx,
    output logic [DATA_W-1:0] alu_opnd,
    output flg_t              alu_fin,
    input  logic [DATA_W-1:0] alu_res,
    input  flg_t              alu_fout,
    input  logic              alu_wb,
    input  logic              alu_fwe,
    // write-back
    output logic              rf_we,
    output logic [SEL_W-1:0]  rf_wsel,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              flag_we,
    output logic [DATA_W-1:0] flag_wdata,
    // memory
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    input  logic              mem_wr_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    // status
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cycles
);

    localparam logic [CNT_W-1:0] CNT_REG = CNT_W'(CYC_REG);
    localparam logic [CNT_W-1:0] CNT_MEM = CNT_W'(CYC_MEM);

    typedef struct packed {
        phase_e            ph;
        grp_e              grp;
        logic [IDX_W-1:0]  idx;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        flg_t              fin;
        logic [DATA_W-1:0] tmp;
        logic [DATA_W-1:0] res;
        flg_t              fout;
        logic              rf_we;
        logic              f_we;
        logic [CNT_W-1:0]  cyc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        alu_grp  = dec.grp;
        alu_idx  = dec.idx;
        alu_opnd = rf_rdata;
        alu_fin  = flags_in;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.grp  = dec.grp;
                    st_d.idx  = dec.idx;
                    st_d.sel  = dec.sel;
                    st_d.addr = hl_addr;
                    st_d.fin  = flags_in;
                    if (is_mem) begin
                        st_d.ph    = PH_READ;
                        st_d.rf_we = 1'b0;
                        st_d.f_we  = 1'b0;
                        st_d.cyc   = CNT_MEM;
                    end else begin
                        st_d.ph    = PH_DONE;
                        st_d.res   = alu_res;
                        st_d.fout  = alu_fout;
                        st_d.rf_we = alu_wb;
                        st_d.f_we  = alu_fwe;
                        st_d.cyc   = CNT_REG;
                    end
                end
            end
            PH_READ: begin
                if (mem_rd_ack) begin
                    st_d.tmp = mem_rd_data;
                    st_d.ph  = PH_MODIFY;
                end
            end
            PH_MODIFY: begin
                alu_grp   = st_q.grp;
                alu_idx   = st_q.idx;
                alu_opnd  = st_q.tmp;
                alu_fin   = st_q.fin;
                st_d.res  = alu_res;
                st_d.fout = alu_fout;
                st_d.f_we = alu_fwe;
                st_d.ph   = alu_wb ? PH_WRITE : PH_DONE;
            end
            PH_WRITE: begin
                if (mem_wr_ack) begin
                    st_d.ph = PH_DONE;
                end
            end
            PH_DONE: begin
                st_d.ph = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy        = (st_q.ph != PH_IDLE);
        done        = (st_q.ph == PH_DONE);
        mem_rd_req  = (st_q.ph == PH_READ);
        mem_wr_req  = (st_q.ph == PH_WRITE);
        mem_addr    = st_q.addr;
        mem_wr_data = st_q.res;
        rf_we       = done && st_q.rf_we;
        rf_wsel     = st_q.sel;
        rf_wdata    = st_q.res;
        flag_we     = done && st_q.f_we;
        flag_wdata  = {st_q.fout, {NIB_W{1'b0}}};
        cycles      = st_q.cyc;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one clock"); // R11

    AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !is_mem) |=> (done && cycles == CNT_REG && !mem_rd_req)) else $error("register op latency"); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_addr))) else $error("read request dropped"); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data) && $stable(mem_addr))) else $error("write request dropped"); // R9

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_MODIFY && st_q.grp == GRP_TEST) |=> (!mem_wr_req && done)) else $error("bit test wrote memory"); // R6

    AST_MARK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (st_q.grp == GRP_CLR || st_q.grp == GRP_SET)) |-> !flag_we) else $error("clear/set wrote flags"); // R7

    AST_MEM_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |=> !rf_we) else $error("memory op wrote register"); // R2

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned CYC_REG = 2,
    parameter int unsigned CYC_MEM = 4,
    parameter int unsigned CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [3:0]        flags_in,
    input  logic [ADDR_W-1:0] hl_addr,
    output logic [2:0]        rf_rsel,
    input  logic [7:0]        rf_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_wsel,
    output logic [7:0]        rf_wdata,
    output logic              flag_we,
    output logic [7:0]        flag_wdata,
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_req,
    input  logic              mem_wr_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wr_data,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cycles
);

    dec_t              dec;
    logic              is_mem;
    grp_e              alu_grp;
    logic [IDX_W-1:0]  alu_idx;
    logic [DATA_W-1:0] alu_opnd;
    flg_t              alu_fin;
    logic [DATA_W-1:0] alu_res;
    flg_t              alu_fout;
    logic              alu_wb;
    logic              alu_fwe;

    bitop_decode u_decode (
        .opcode (opcode),
        .dec    (dec),
        .is_mem (is_mem)
    );

    assign rf_rsel = dec.sel;

    bitop_alu u_alu (
        .grp  (alu_grp),
        .idx  (alu_idx),
        .opnd (alu_opnd),
        .fin  (alu_fin),
        .res  (alu_res),
        .fout (alu_fout),
        .wb   (alu_wb),
        .fwe  (alu_fwe)
    );

    bitop_seq #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .CYC_REG (CYC_REG),
        .CYC_MEM (CYC_MEM)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec         (dec),
        .is_mem      (is_mem),
        .flags_in    (flg_t'(flags_in)),
        .hl_addr     (hl_addr),
        .rf_rdata    (rf_rdata),
        .alu_grp     (alu_grp),
        .alu_idx     (alu_idx),
        .alu_opnd    (alu_opnd),
        .alu_fin     (alu_fin),
        .alu_res     (alu_res),
        .alu_fout    (alu_fout),
        .alu_wb      (alu_wb),
        .alu_fwe     (alu_fwe),
        .rf_we       (rf_we),
        .rf_wsel     (rf_wsel),
        .rf_wdata    (rf_wdata),
        .flag_we     (flag_we),
        .flag_wdata  (flag_wdata),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .mem_wr_req  (mem_wr_req),
        .mem_wr_ack  (mem_wr_ack),
        .mem_addr    (mem_addr),
        .mem_wr_data (mem_wr_data),
        .busy        (busy),
        .done        (done),
        .cycles      (cycles)
    );

    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_wdata[3:0] == 4'h0)) else $error("flag low nibble"); // R10

endmodule

// File: tb/bitop_exec_bench.sv
module bitop_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  flags_in = 4'h0;
    logic [15:0] hl_addr = 16'h0000;
    logic [2:0]  rf_rsel;
    logic [7:0]  rf_rdata;
    logic        rf_we;
    logic [2:0]  rf_wsel;
    logic [7:0]  rf_wdata;
    logic        flag_we;
    logic [7:0]  flag_wdata;
    logic        mem_rd_req;
    logic        mem_rd_ack = 1'b0;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        mem_wr_req;
    logic        mem_wr_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wr_data;
    logic        busy;
    logic        done;
    logic [2:0]  cycles;

    logic [7:0]  rf [8];
    logic [7:0]  mem [256];
    int          rd_lat = 0, wr_lat = 0, rd_cnt = 0, wr_cnt = 0;
    int          wr_count = 0;
    logic [15:0] wr_addr_seen = 16'h0;
    int          nchk = 0, nfail = 0, cyc = 0;
    bit          finished = 0;

    assign rf_rdata = rf[rf_rsel];

    always #10 clk = ~clk;

    bitop_exec u_bitop_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flags_in(flags_in), .hl_addr(hl_addr), .rf_rsel(rf_rsel),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wsel(rf_wsel),
        .rf_wdata(rf_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
        .mem_wr_ack(mem_wr_ack), .mem_addr(mem_addr),
        .mem_wr_data(mem_wr_data), .busy(busy), .done(done), .cycles(cycles)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model: {flag_we, reg/mem write, Z N H C, result}
    function automatic logic [13:0] ref_op(input logic [7:0] op, input logic [7:0] a,
                                           input logic [3:0] f);
        int g, k, v, r, cin;
        logic c, wb, fw;
        logic [3:0] fo;
        g = int'(op[7:6]); k = int'(op[5:3]); v = int'(a); cin = int'(f[0]);
        r = v; c = 1'b0; fo = f; wb = 1'b1; fw = 1'b1;
        if (g == 0) begin
            case (k)
                0: begin r = (v * 2) % 256 + v / 128;      c = (v >= 128); end
                1: begin r = v / 2 + (v % 2) * 128;        c = (v % 2 == 1); end
                2: begin r = (v * 2) % 256 + cin;          c = (v >= 128); end
                3: begin r = v / 2 + cin * 128;            c = (v % 2 == 1); end
                4: begin r = (v * 2) % 256;                c = (v >= 128); end
                5: begin r = v / 2 + ((v >= 128) ? 128 : 0); c = (v % 2 == 1); end
                6: begin r = (v % 16) * 16 + v / 16;       c = 1'b0; end
                default: begin r = v / 2;                  c = (v % 2 == 1); end
            endcase
            fo = {(r == 0), 1'b0, 1'b0, c};
        end else if (g == 1) begin
            fo = {(((v >> k) & 1) == 0), 1'b0, 1'b1, f[0]};
            wb = 1'b0;
        end else if (g == 2) begin
            r = v & (255 - (1 << k));
            fw = 1'b0;
        end else begin
            r = v | (1 << k);
            fw = 1'b0;
        end
        return {fw, wb, fo, 8'(r)};
    endfunction

    // Memory responder: acknowledges after a programmable delay.
    always @(negedge clk) begin
        mem_rd_ack = 1'b0;
        mem_wr_ack = 1'b0;
        if (mem_rd_req) begin
            if (rd_cnt >= rd_lat) begin
                mem_rd_ack  = 1'b1;
                mem_rd_data = mem[mem_addr[7:0]];
                rd_cnt = 0;
            end else rd_cnt++;
        end
        if (mem_wr_req) begin
            if (wr_cnt >= wr_lat) begin
                mem_wr_ack = 1'b1;
                mem[mem_addr[7:0]] = mem_wr_data;
                wr_addr_seen = mem_addr;
                wr_count++;
                wr_cnt = 0;
            end else wr_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    function automatic string grp_tag(input logic [7:0] op);
        case (op[7:6])
            2'b00: return "R3";
            2'b01: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic do_reg(input logic [7:0] op, input logic [3:0] f);
        logic [13:0] e;
        e = ref_op(op, rf[op[2:0]], f);
        opcode = op; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 done after one clock", int'(done), 1);
        chk("R8 cycles", int'(cycles), 2);
        chk("R2 no memory read on register op", int'(mem_rd_req), 0);
        chk({grp_tag(op), " R1 register write enable"}, int'(rf_we), int'(e[12]));
        if (e[12]) begin
            chk("R2 write selector", int'(rf_wsel), int'(op[2:0]));
            chk({grp_tag(op), " R1 result"}, int'(rf_wdata), int'(e[7:0]));
        end
        chk({grp_tag(op), " flag write enable"}, int'(flag_we), int'(e[13]));
        if (e[13]) begin
            chk(op[7:6] == 2'b00 ? "R4 R5 flags" : "R6 flags", int'(flag_wdata[7:4]), int'(e[11:8]));
            chk("R10 flag low nibble", int'(flag_wdata[3:0]), 0);
        end
        @(negedge clk);
        chk("R11 done single pulse", int'(done), 0);
    endtask

    task automatic do_mem(input logic [7:0] op, input logic [3:0] f, input logic [15:0] addr,
                          input int rl, input int wl, input bit stray);
        logic [13:0] e;
        logic [7:0]  orig;
        int          n, w0;
        bit          seen;
        orig = mem[addr[7:0]];
        e = ref_op(op, orig, f);
        rd_lat = rl; wr_lat = wl; rd_cnt = 0; wr_cnt = 0;
        w0 = wr_count; seen = 0; n = 0;
        opcode = op; flags_in = f; hl_addr = addr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            opcode = 8'hFE; flags_in = ~f; hl_addr = addr ^ 16'h0055; start = 1'b1;
        end
        while (n < 40 && !seen) begin
            if (done) seen = 1;
            else begin
                if (rf_we) chk("R2 memory op raised rf_we", int'(rf_we), 0);
                @(negedge clk);
                start = 1'b0;
                n++;
            end
        end
        chk("R9 done reached", int'(seen), 1);
        chk("R9 cycles", int'(cycles), 4);
        chk("R2 memory op rf_we", int'(rf_we), 0);
        chk(e[12] ? "R9 one write" : "R6 no write", wr_count - w0, e[12] ? 1 : 0);
        if (e[12]) begin
            chk("R2 write address", int'(wr_addr_seen), int'(addr));
            chk({grp_tag(op), " R9 memory result"}, int'(mem[addr[7:0]]), int'(e[7:0]));
        end else begin
            chk("R6 memory unchanged", int'(mem[addr[7:0]]), int'(orig));
        end
        chk({grp_tag(op), " flag write enable (mem)"}, int'(flag_we), int'(e[13]));
        if (e[13]) chk("R10 flags (mem)", int'(flag_wdata), int'({e[11:8], 4'h0}));
        @(negedge clk);
        chk("R11 done single pulse (mem)", int'(done), 0);
        if (stray) chk("R11 stray start ignored", int'(busy), 0);
    endtask

    initial begin
        logic [7:0] vals [5];
        vals[0] = 8'h00; vals[1] = 8'h80; vals[2] = 8'h01; vals[3] = 8'hF0; vals[4] = 8'hA5;
        for (int i = 0; i < 8; i++) rf[i] = 8'h00;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        @(negedge clk);
        chk("R12 reset done", int'(done), 0);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset read req", int'(mem_rd_req), 0);
        chk("R12 reset write req", int'(mem_wr_req), 0);
        chk("R12 reset rf_we", int'(rf_we), 0);
        chk("R12 reset flag_we", int'(flag_we), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", int'(busy), 0);

        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 256; op++) begin
                if (op % 8 != 6) begin
                    for (int i = 0; i < 8; i++) rf[i] = vals[(p + i + op / 8) % 5];
                    do_reg(8'(op), 4'((p * 5 + op) % 16));
                end
            end
        end

        for (int k = 0; k < 32; k++) begin
            do_mem(8'((k << 3) | 6), 4'(k % 16), 16'h8000 + 16'(k * 7),
                   k % 3, (k + 1) % 3, (k % 4) == 0);
            do_mem(8'((k << 3) | 6), 4'((k + 9) % 16), 16'h4000 + 16'(k * 3),
                   (k + 2) % 3, k % 2, (k % 4) == 2);
        end

        // Directed corners: zero results from shifts and swap carry.
        rf[7] = 8'h80; do_reg(8'h27, 4'h0);   // SLA A -> 0, Z=1 C=1 (R5, R4)
        rf[0] = 8'h01; do_reg(8'h38, 4'hF);   // SRL B -> 0, Z=1 C=1 (R5)
        rf[1] = 8'hF0; do_reg(8'h31, 4'h1);   // SWAP C -> 0F, C cleared (R4)
        rf[2] = 8'h00; do_reg(8'h02, 4'h0);   // RLC D of zero, Z=1 (R5)

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule